// File: doc/BRIEF.md
# TDD Transmit Mode Sequencer

This block sits in the transmit path of a time-division-duplex link. It turns a coarse transmit mode from PHY control into a per-symbol internal transmit mode. The coarse mode says only which kind of repeating ON/OFF activity is wanted: symmetric training, asymmetric training, extended asymmetric training, data, or nothing. The sequencer works out when the local side may drive the line, which training or data slot type applies, whether PAM2 or PAM4 is used, and which of the two symbol rates (3 Gsps or 6 Gsps) is selected. For the framer it also raises a flag during the leading header symbols of every burst.

Time is counted in symbol ticks. One TDD cycle has a programmable length in ticks and is split into an ON length and an OFF length. A master bursts at the start of the cycle and a slave bursts at the end, so the two ends alternate on the line. The link-rate variant and the role are static configuration. A new coarse mode is adopted only at a cycle boundary, so a burst that has started always completes. Only the 100M-to-10G and 10G-to-100M variants accept extended asymmetric training. In the 10G-side case the burst starts in PAM2 and changes to PAM4 once the header has ended.

Top module: `tdd_tx_sequencer`

## Requirements
- R1: While reset is held, and directly after it, im_code, tx_on, mod_pam4, rate_6g and hdr_phase are all 0, and the cycle is idle (silent).
- R2: cfg_err is 1 whenever cfg_on_len + cfg_off_len differs from cfg_cycle_len, cfg_on_len is 0, or cfg_hdr_len exceeds cfg_on_len. While cfg_err is 1 the outputs are quiet, and the cycle returns to idle.
- R3: The slot index counts sym_tick pulses from 0 at the start of a cycle and wraps after cfg_cycle_len - 1. A master (cfg_slave=0) has tx_on=1 for index < cfg_on_len. A slave has tx_on=1 for index >= cfg_off_len. Without a tick the index holds.
- R4: Whenever tx_on is 0, im_code, mod_pam4, rate_6g and hdr_phase are all 0 (quiet slot, zero symbols).
- R5: Symmetric training (mode_in=1) gives im_code=1 in ON slots, with PAM2 at 3 Gsps for every valid variant.
- R6: Asymmetric training (mode_in=2) gives im_code=2 with PAM2. rate_6g is 1 for variants 4 (5G side) and 5 (10G side) and 0 for variants 0 to 3.
- R7: Extended asymmetric training (mode_in=3) is accepted only for variant 2 (100M side of 10G pair) and variant 5 (10G side). It gives im_code=3. Variant 2 uses PAM2 at 3 Gsps. Variant 5 uses 6 Gsps, with PAM2 while hdr_phase=1 and PAM4 after it. For any other variant the request acts as silent.
- R8: Data mode (mode_in=4) gives im_code=4. Variants 0 to 3 use PAM2 at 3 Gsps, variant 4 uses PAM4 at 3 Gsps, and variant 5 uses PAM4 at 6 Gsps.
- R9: hdr_phase is 1 for the first cfg_hdr_len slot indexes of each ON slot (counted from the slot's start) and is 0 otherwise.
- R10: A change of mode_in during a cycle does not alter the outputs until the tick that wraps the slot index to 0.
- R11: While silent is active the slot index stays at 0. From idle, the next tick adopts mode_in and starts a cycle at index 0.
- R12: mode_in values 0 and 5 to 7, and variants 6 and 7, are treated as silent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_tick | input | 1 | One pulse per symbol time |
| mode_in | input | 3 | Coarse mode: 0 silent, 1 symmetric, 2 asymmetric, 3 extended, 4 data |
| cfg_variant | input | 3 | Link variant: 0 100M/2.5G, 1 100M/5G, 2 100M/10G, 3 2.5G/100M, 4 5G/100M, 5 10G/100M |
| cfg_slave | input | 1 | 0 master (bursts first), 1 slave (bursts last) |
| cfg_cycle_len | input | CNT_W | TDD cycle length in ticks |
| cfg_on_len | input | CNT_W | ON slot length in ticks |
| cfg_off_len | input | CNT_W | OFF slot length in ticks |
| cfg_hdr_len | input | CNT_W | Header length in ticks at the start of each ON slot |
| im_code | output | 3 | Internal mode: 0 quiet, 1 symmetric train, 2 PAM2 train, 3 extended train, 4 data |
| tx_on | output | 1 | Local burst active |
| mod_pam4 | output | 1 | 1 PAM4, 0 PAM2 |
| rate_6g | output | 1 | 1 selects 6 Gsps, 0 selects 3 Gsps |
| hdr_phase | output | 1 | Header portion of the burst |
| cfg_err | output | 1 | Slot lengths inconsistent |

## Verification
The hardest case to reach from the ports is a mode change that lands in the middle of a burst. The new value has to be ignored until the wrap, even though the PAM2-to-PAM4 switch inside the 10G-side extended burst is still running. The bench runs a small eight-tick cycle. It sweeps every mode code, variant and role, with tick gaps inserted. In separate phases it changes the mode partway through a cycle, moves from silent back to active, and breaks the slot lengths while a burst is in progress. A tick-accurate arithmetic model predicts every output.

// File: rtl/tdd_seq_pkg.sv
package tdd_seq_pkg;

    localparam int MODE_W = 3;
    localparam int VAR_W  = 3;

    typedef enum logic [MODE_W-1:0] {
        TXM_SILENT = 3'd0,
        TXM_SYM    = 3'd1,
        TXM_ASYM   = 3'd2,
        TXM_EXT    = 3'd3,
        TXM_DATA   = 3'd4
    } txm_e;

    // link variants: first rate is this side's transmit direction
    localparam logic [VAR_W-1:0] VAR_LO_2P5  = 3'd0;
    localparam logic [VAR_W-1:0] VAR_LO_5G   = 3'd1;
    localparam logic [VAR_W-1:0] VAR_LO_10G  = 3'd2;
    localparam logic [VAR_W-1:0] VAR_MID_2P5 = 3'd3;
    localparam logic [VAR_W-1:0] VAR_HI_5G   = 3'd4;
    localparam logic [VAR_W-1:0] VAR_HI_10G  = 3'd5;

    typedef struct packed {
        logic [2:0] code;
        logic       on;
        logic       pam4;
        logic       r6g;
        logic       hdr;
    } slot_out_t;

endpackage

// File: rtl/tdd_mode_resolver.sv
module tdd_mode_resolver
    import tdd_seq_pkg::*;
(
    input  logic [MODE_W-1:0] mode_raw,
    input  logic [VAR_W-1:0]  variant,
    output txm_e              mode_res
);
    logic var_ok;
    logic ext_ok;

    always_comb begin
        var_ok = (variant <= VAR_HI_10G);
        ext_ok = (variant == VAR_LO_10G) || (variant == VAR_HI_10G);
        mode_res = TXM_SILENT;
        if (var_ok) begin
            case (mode_raw)
                3'd1:    mode_res = TXM_SYM;
                3'd2:    mode_res = TXM_ASYM;
                3'd3:    mode_res = ext_ok ? TXM_EXT : TXM_SILENT;
                3'd4:    mode_res = TXM_DATA;
                default: mode_res = TXM_SILENT;
            endcase
        end
    end
endmodule

// File: rtl/tdd_cycle_ctrl.sv
module tdd_cycle_ctrl
    import tdd_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cfg_bad,
    input  txm_e             mode_res,
    input  logic [CNT_W-1:0] cycle_len,
    output txm_e             act_mode,
    output logic [CNT_W-1:0] slot_idx
);
    typedef struct packed {
        txm_e             act;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t st_d, st_q;
    logic last_slot;

    always_comb begin
        st_d      = st_q;
        last_slot = (st_q.cnt == cycle_len - CNT_W'(1));
        if (cfg_bad) begin
            st_d.act = TXM_SILENT;
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.act == TXM_SILENT) begin
                st_d.act = mode_res;
                st_d.cnt = '0;
            end else if (last_slot) begin
                st_d.act = mode_res;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.act <= TXM_SILENT;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_mode = st_q.act;
    assign slot_idx = st_q.cnt;
endmodule

// File: rtl/tdd_slot_decoder.sv
module tdd_slot_decoder
    import tdd_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  txm_e             act_mode,
    input  logic [CNT_W-1:0] slot_idx,
    input  logic             slave,
    input  logic [VAR_W-1:0] variant,
    input  logic [CNT_W-1:0] on_len,
    input  logic [CNT_W-1:0] off_len,
    input  logic [CNT_W-1:0] hdr_len,
    input  logic             cfg_bad,
    output slot_out_t        so
);
    logic             in_burst;
    logic [CNT_W-1:0] burst_ofs;
    logic             hi_side;

    always_comb begin
        so        = '0;
        hi_side   = (variant == VAR_HI_5G) || (variant == VAR_HI_10G);
        in_burst  = slave ? (slot_idx >= off_len) : (slot_idx < on_len);
        burst_ofs = slave ? (slot_idx - off_len) : slot_idx;
        if (!cfg_bad && act_mode != TXM_SILENT && in_burst) begin
            so.on   = 1'b1;
            so.code = 3'(act_mode);
            so.hdr  = (burst_ofs < hdr_len);
            case (act_mode)
                TXM_ASYM: so.r6g = hi_side;
                TXM_EXT: begin
                    so.r6g  = (variant == VAR_HI_10G);
                    so.pam4 = (variant == VAR_HI_10G) && !so.hdr;
                end
                TXM_DATA: begin
                    so.pam4 = hi_side;
                    so.r6g  = (variant == VAR_HI_10G);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tdd_tx_sequencer.sv
module tdd_tx_sequencer
    import tdd_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_tick,
    input  logic [2:0]       mode_in,
    input  logic [2:0]       cfg_variant,
    input  logic             cfg_slave,
    input  logic [CNT_W-1:0] cfg_cycle_len,
    input  logic [CNT_W-1:0] cfg_on_len,
    input  logic [CNT_W-1:0] cfg_off_len,
    input  logic [CNT_W-1:0] cfg_hdr_len,
    output logic [2:0]       im_code,
    output logic             tx_on,
    output logic             mod_pam4,
    output logic             rate_6g,
    output logic             hdr_phase,
    output logic             cfg_err
);
    localparam int SUM_W = CNT_W + 1;

    txm_e             mode_res;
    txm_e             act_mode;
    logic [CNT_W-1:0] slot_idx;
    slot_out_t        so;
    logic [SUM_W-1:0] len_sum;

    always_comb begin
        len_sum = SUM_W'(cfg_on_len) + SUM_W'(cfg_off_len);
        cfg_err = (len_sum != SUM_W'(cfg_cycle_len))
               || (cfg_on_len == '0)
               || (cfg_hdr_len > cfg_on_len);
    end

    tdd_mode_resolver res_i (
        .mode_raw (mode_in),
        .variant  (cfg_variant),
        .mode_res (mode_res)
    );

    tdd_cycle_ctrl #(.CNT_W(CNT_W)) ctl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sym_tick),
        .cfg_bad   (cfg_err),
        .mode_res  (mode_res),
        .cycle_len (cfg_cycle_len),
        .act_mode  (act_mode),
        .slot_idx  (slot_idx)
    );

    tdd_slot_decoder #(.CNT_W(CNT_W)) dec_i (
        .act_mode (act_mode),
        .slot_idx (slot_idx),
        .slave    (cfg_slave),
        .variant  (cfg_variant),
        .on_len   (cfg_on_len),
        .off_len  (cfg_off_len),
        .hdr_len  (cfg_hdr_len),
        .cfg_bad  (cfg_err),
        .so       (so)
    );

    assign im_code   = so.code;
    assign tx_on     = so.on;
    assign mod_pam4  = so.pam4;
    assign rate_6g   = so.r6g;
    assign hdr_phase = so.hdr;
endmodule

// File: rtl/tdd_tx_sequencer_chk.sv
module tdd_tx_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sym_tick,
    input logic [2:0] cfg_variant,
    input logic [2:0] im_code,
    input logic       tx_on,
    input logic       mod_pam4,
    input logic       rate_6g,
    input logic       hdr_phase,
    input logic       cfg_err
);
    AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_on |-> (im_code == 3'd0 && !mod_pam4 && !rate_6g && !hdr_phase)); // R4
    AST_CFG_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !tx_on); // R2
    AST_HDR_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_phase |-> tx_on); // R9
    AST_SYM_PAM2_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (im_code == 3'd1) |-> (!mod_pam4 && !rate_6g)); // R5
    AST_EXT_VARIANT: assert property (@(posedge clk) disable iff (!rst_n)
        (im_code == 3'd3) |-> (cfg_variant == 3'd2 || cfg_variant == 3'd5)); // R7
    AST_EXT_HDR_PAM2: assert property (@(posedge clk) disable iff (!rst_n)
        (im_code == 3'd3 && hdr_phase) |-> !mod_pam4); // R7
    AST_PAM4_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        mod_pam4 |-> (im_code == 3'd3 || im_code == 3'd4)); // R8
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!sym_tick && !cfg_err) |=> (cfg_err || ($stable(im_code) && $stable(tx_on)))); // R3
endmodule

bind tdd_tx_sequencer tdd_tx_sequencer_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sym_tick    (sym_tick),
    .cfg_variant (cfg_variant),
    .im_code     (im_code),
    .tx_on       (tx_on),
    .mod_pam4    (mod_pam4),
    .rate_6g     (rate_6g),
    .hdr_phase   (hdr_phase),
    .cfg_err     (cfg_err)
);

// File: tb/tdd_tx_sequencer_tb_top.sv
`timescale 1ns/1ps
module tdd_tx_sequencer_tb_top;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sym_tick = 1'b0;
    logic [2:0]    mode_in = 3'd0;
    logic [2:0]    cfg_variant = 3'd0;
    logic          cfg_slave = 1'b0;
    logic [CW-1:0] cfg_cycle_len = 16'd8;
    logic [CW-1:0] cfg_on_len = 16'd3;
    logic [CW-1:0] cfg_off_len = 16'd5;
    logic [CW-1:0] cfg_hdr_len = 16'd1;
    logic [2:0]    im_code;
    logic          tx_on, mod_pam4, rate_6g, hdr_phase, cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    int m_act = 0;
    int m_cnt = 0;
    string tag_ovr = "";

    always #5 clk = ~clk;

    tdd_tx_sequencer #(.CNT_W(CW)) dut_i (
        .clk, .rst_n, .sym_tick, .mode_in, .cfg_variant, .cfg_slave,
        .cfg_cycle_len, .cfg_on_len, .cfg_off_len, .cfg_hdr_len,
        .im_code, .tx_on, .mod_pam4, .rate_6g, .hdr_phase, .cfg_err
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (mode=%0d var=%0d slave=%0d idx=%0d)",
                     tag, act, exp, mode_in, cfg_variant, cfg_slave, m_cnt);
        end
    endtask

    function automatic bit m_err();
        return (int'(cfg_on_len) + int'(cfg_off_len) != int'(cfg_cycle_len))
            || cfg_on_len == 0 || cfg_hdr_len > cfg_on_len;
    endfunction

    function automatic int m_res();
        int v = int'(cfg_variant);
        int m = int'(mode_in);
        if (v >= 6) return 0;
        if (m == 1 || m == 2 || m == 4) return m;
        if (m == 3) return (v == 2 || v == 5) ? 3 : 0;
        return 0;
    endfunction

    task automatic model_edge();
        if (!rst_n || m_err()) begin
            m_act = 0; m_cnt = 0;
        end else if (sym_tick) begin
            if (m_act == 0 || m_cnt == int'(cfg_cycle_len) - 1) begin
                m_act = m_res(); m_cnt = 0;
            end else m_cnt++;
        end
    endtask

    task automatic compare(input string force_tag);
        int v = int'(cfg_variant);
        bit e_err = m_err();
        bit e_on, e_hdr, e_r6, e_p4;
        int ofs;
        string t;
        e_on  = !e_err && m_act != 0 &&
                (cfg_slave ? (m_cnt >= int'(cfg_off_len)) : (m_cnt < int'(cfg_on_len)));
        ofs   = cfg_slave ? m_cnt - int'(cfg_off_len) : m_cnt;
        e_hdr = e_on && ofs < int'(cfg_hdr_len);
        e_r6  = e_on && ((m_act == 2 && (v == 4 || v == 5)) || (m_act == 3 && v == 5)
                      || (m_act == 4 && v == 5));
        e_p4  = e_on && ((m_act == 3 && v == 5 && !e_hdr) || (m_act == 4 && (v == 4 || v == 5)));
        if (force_tag != "") t = force_tag;
        else if (e_err) t = "R2";
        else if (mode_in >= 5 || v >= 6) t = "R12";
        else if (!e_on) t = "R4";
        else if (m_act == 1) t = "R5";
        else if (m_act == 2) t = "R6";
        else if (m_act == 3) t = "R7";
        else t = "R8";
        chk("R2", int'(cfg_err), int'(e_err));
        chk("R3", int'(tx_on), int'(e_on));
        chk("R9", int'(hdr_phase), int'(e_hdr));
        chk(t, int'(im_code), e_on ? m_act : 0);
        chk(t, int'(rate_6g), int'(e_r6));
        chk(t, int'(mod_pam4), int'(e_p4));
    endtask

    task automatic step(input bit tk);
        sym_tick = tk;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag_ovr);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sym_tick = 1'b0;
        @(posedge clk); model_edge();
        @(posedge clk); model_edge();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk("R1", int'(im_code), 0);
        chk("R1", int'(tx_on), 0);
        chk("R1", int'(mod_pam4) + int'(rate_6g) + int'(hdr_phase), 0);

        // sweep: every mode code, variant and role; header of 2 ticks
        cfg_hdr_len = 16'd2;
        for (int m = 0; m < 8; m++) begin
            for (int v = 0; v < 8; v++) begin
                for (int s = 0; s < 2; s++) begin
                    cfg_variant = 3'(v);
                    cfg_slave   = 1'(s);
                    mode_in     = 3'(m);
                    do_reset();
                    for (int k = 0; k < 20; k++) step((k % 5) != 4);
                end
            end
        end

        // R10: mid-cycle change is deferred to the wrap
        cfg_variant = 3'd5; cfg_slave = 1'b0; mode_in = 3'd1;
        do_reset();
        step(1'b1); step(1'b1);
        tag_ovr = "R10";
        mode_in = 3'd4;
        for (int k = 0; k < 10; k++) step(1'b1);
        mode_in = 3'd3;
        for (int k = 0; k < 10; k++) step(1'b1);

        // R11: silent at the wrap, index held, restart from index 0
        tag_ovr = "R11";
        mode_in = 3'd0;
        for (int k = 0; k < 12; k++) step(1'b1);
        mode_in = 3'd3;
        step(1'b0);
        step(1'b1);
        chk("R11", int'(im_code), 3);
        for (int k = 0; k < 9; k++) step(1'b1);

        // R2: broken lengths during a burst, then restored
        tag_ovr = "";
        do_reset();
        step(1'b1);
        cfg_off_len = 16'd4;
        step(1'b1); step(1'b1);
        cfg_off_len = 16'd5; cfg_hdr_len = 16'd4;
        step(1'b1); step(1'b1);
        cfg_hdr_len = 16'd2; cfg_on_len = 16'd0; cfg_off_len = 16'd8;
        step(1'b1);
        cfg_on_len = 16'd3; cfg_off_len = 16'd5;
        for (int k = 0; k < 10; k++) step(1'b1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule